// File: doc/BRIEF.md
# Control Register File with Banked Stack Pointers

This block holds a processor's control registers behind one combinational read port and one clocked write port, both selected by a small index. It keeps the status word and its backup copy, a second-level backup status, the condition flag, two saved return addresses and two spare words. Several of these registers are not returned as plain storage. The status word is assembled from three sources on every read, and the saved return addresses always read back as even values.

The block also owns the live stack pointer that the general register file presents as its stack register. Two banked copies sit beside it: one for the interrupt stack and one for the user stack. A stack-mode bit in the status word selects which bank is live. A status write that flips that bit saves the live pointer into the outgoing bank and loads the incoming bank, all in the same clock edge. The live pointer has its own read and write port for the general register path.

A multiply-accumulate accumulator is held here as well. Software writes it as two 32-bit halves and reads it as a 64-bit value that is sign-extended from the stored width.

Top module: `ctlreg_file`

## Requirements
- R1: Reading index 0 (status) returns, in bits 15:14 and 8, the backup status bits 15:14 and 8 from the last status write. Bits 7:6 are the current status bits 7:6 and bit 0 is the condition flag. Every other bit reads 0.
- R2: A write to index 0 loads the backup status from bits 15:8 and the status from bits 7:0, and copies bit 0 into the condition flag.
- R3: Reading index 1 returns the condition flag in bit 0 with zeros above it. A write to index 1 sets the condition flag from bit 0 of the data.
- R4: Status bit 7 is the stack mode (0 = interrupt stack live, 1 = user stack live). A status write that moves it from 0 to 1 saves the live pointer into the interrupt bank and loads the live pointer from the user bank. A move from 1 to 0 saves the live pointer into the user bank and loads it from the interrupt bank. A status write that keeps the mode leaves all three pointers unchanged.
- R5: Index 2 (interrupt stack) reads and writes the live pointer when the mode is 0 and the interrupt bank otherwise. Index 3 (user stack) reads and writes the live pointer when the mode is 1 and the user bank otherwise.
- R6: Indices 6 and 7 (saved return addresses) take the full 32-bit write and read back with bit 0 forced to 0.
- R7: Index 8 (second-level backup status) keeps bits 7:0 of a write and reads back only bits 7, 6 and 0, with zeros elsewhere.
- R8: Indices 4 and 5 are plain 32-bit storage. Indices 9 to 15 read as 0, and a write to them changes no register.
- R9: The accumulator output bits 55:0 hold the stored value and bits 63:56 copy bit 55. A low-half write loads bits 31:0 from the data. A high-half write loads bits 55:32 from data bits 23:0. Each half write leaves the other half unchanged.
- R10: A write on the stack-pointer port loads the live pointer. The write is ignored in a cycle where a control write also lands on the live pointer, either through index 2 or 3 or through a mode swap.
- R11: After reset every control index reads 0, and the live pointer, both banks and the accumulator are 0.
- R12: Reads are combinational from the stored state. A read in the same cycle as a write to that register returns the value from before the write, and the new value appears after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| cr_idx | input | IDX_W (4) | Control register index for both read and write |
| rd_data | output | 32 | Combinational read value of the indexed register |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write data |
| sp_rd_data | output | 32 | Live stack pointer value |
| sp_wr_en | input | 1 | Live stack pointer write strobe from the general register path |
| sp_wr_data | input | 32 | Live stack pointer write data |
| acc_rd_data | output | 64 | Sign-extended accumulator value |
| acc_lo_we | input | 1 | Accumulator low-half write strobe |
| acc_hi_we | input | 1 | Accumulator high-half write strobe |
| acc_wr_data | input | 32 | Accumulator half write data |

## Verification
A wrong bank swap does not show at once. The live pointer output moves on the edge after the status write, but a bank that was saved wrongly shows only when index 2 or 3 is read in the opposite mode, or after the next mode flip brings the bank back. The directed sequences therefore walk the mode through 0, 1, 1 and 0 and read both banks and the live pointer after each step. A broken read composition or mask shows at rd_data in the same cycle the index is presented. The accumulator halves are checked after each single-half write, so that a half write that corrupts the other half shows one edge later.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  localparam int XLEN = 32;

  // control register index map
  localparam int IX_STATUS  = 0;
  localparam int IX_COND    = 1;
  localparam int IX_ISTACK  = 2;
  localparam int IX_USTACK  = 3;
  localparam int IX_SPARE0  = 4;
  localparam int IX_SPARE1  = 5;
  localparam int IX_RET0    = 6;
  localparam int IX_RET1    = 7;
  localparam int IX_STATUS2 = 8;

  // plain storage bank: spares then return addresses
  localparam int STORE_BASE = IX_SPARE0;
  localparam int STORE_N    = 4;
  localparam int STORE_MASK_FROM = 2;

  localparam int MODE_BIT = 7;

endpackage

// File: rtl/cr_psw_unit.sv
module cr_psw_unit
  import ctlreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             we_status,
  input  logic             we_cond,
  input  logic             we_status2,
  input  logic [15:0]      wd,
  output logic [XLEN-1:0]  status_view,
  output logic [XLEN-1:0]  cond_view,
  output logic [XLEN-1:0]  status2_view,
  output logic             cur_sm,
  output logic             swap_req
);

  // only the bits that are ever visible are kept
  logic [1:0] mode_q, mode_d;     // status bits 7:6
  logic [2:0] bk_q, bk_d;         // backup bits 15,14,8
  logic [2:0] bb_q, bb_d;         // second-level bits 7,6,0
  logic       cond_q, cond_d;
  logic       unused_wd_bits;

  assign unused_wd_bits = ^{wd[13:9], wd[5:1]};

  always_comb begin
    mode_d = mode_q;
    bk_d   = bk_q;
    bb_d   = bb_q;
    cond_d = cond_q;
    if (we_status) begin
      mode_d = wd[7:6];
      bk_d   = {wd[15:14], wd[8]};
      cond_d = wd[0];
    end
    if (we_cond) begin
      cond_d = wd[0];
    end
    if (we_status2) begin
      bb_d = {wd[7:6], wd[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      bk_q   <= '0;
      bb_q   <= '0;
      cond_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      bk_q   <= bk_d;
      bb_q   <= bb_d;
      cond_q <= cond_d;
    end
  end

  assign cur_sm   = mode_q[1];
  assign swap_req = we_status & (wd[MODE_BIT] != mode_q[1]);

  assign status_view  = {16'b0, bk_q[2:1], 5'b0, bk_q[0], mode_q, 5'b0, cond_q};
  assign cond_view    = {31'b0, cond_q};
  assign status2_view = {24'b0, bb_q[2:1], 5'b0, bb_q[0]};

endmodule

// File: rtl/cr_stack_bank.sv
module cr_stack_bank
  import ctlreg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            cur_sm,
  input  logic            swap_req,
  input  logic            we_istack,
  input  logic            we_ustack,
  input  logic [XLEN-1:0] wd,
  input  logic            sp_we,
  input  logic [XLEN-1:0] sp_wd,
  output logic [XLEN-1:0] live_sp,
  output logic [XLEN-1:0] isp_bank,
  output logic [XLEN-1:0] usp_bank
);

  logic [XLEN-1:0] live_q, live_d;
  logic [XLEN-1:0] isp_q, isp_d;
  logic [XLEN-1:0] usp_q, usp_d;

  always_comb begin
    isp_d  = isp_q;
    usp_d  = usp_q;
    // general register path first; control writes override below
    live_d = sp_we ? sp_wd : live_q;
    if (swap_req) begin
      if (cur_sm) begin
        usp_d  = live_q;
        live_d = isp_q;
      end else begin
        isp_d  = live_q;
        live_d = usp_q;
      end
    end else if (we_istack) begin
      if (cur_sm) isp_d  = wd;
      else        live_d = wd;
    end else if (we_ustack) begin
      if (cur_sm) live_d = wd;
      else        usp_d  = wd;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      isp_q  <= '0;
      usp_q  <= '0;
    end else begin
      live_q <= live_d;
      isp_q  <= isp_d;
      usp_q  <= usp_d;
    end
  end

  assign live_sp  = live_q;
  assign isp_bank = isp_q;
  assign usp_bank = usp_q;

endmodule

// File: rtl/cr_store_bank.sv
module cr_store_bank
  import ctlreg_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int N         = STORE_N,
  parameter int BASE      = STORE_BASE,
  parameter int MASK_FROM = STORE_MASK_FROM
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         idx,
  input  logic [XLEN-1:0]          wd,
  output logic [N-1:0][XLEN-1:0]   views
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [XLEN-1:0] q, d;
    logic            hit;

    assign hit = wr_en && (idx == IDX_W'(BASE + g));

    always_comb begin
      d = q;
      if (hit) d = wd;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end

    if (g >= MASK_FROM) begin : g_even
      logic unused_lsb;
      assign unused_lsb = q[0];
      assign views[g] = {q[XLEN-1:1], 1'b0};
    end else begin : g_plain
      assign views[g] = q;
    end
  end

endmodule

// File: rtl/cr_mac_acc.sv
module cr_mac_acc
  import ctlreg_pkg::*;
#(
  parameter int ACC_W = 56
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic [XLEN-1:0] wd,
  output logic [63:0]     acc_view
);

  localparam int HI_W  = ACC_W - XLEN;
  localparam int EXT_W = 64 - ACC_W;

  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (lo_we) acc_d[XLEN-1:0]     = wd;
    if (hi_we) acc_d[ACC_W-1:XLEN] = wd[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  if (HI_W < XLEN) begin : g_drop
    logic unused_hi_bits;
    assign unused_hi_bits = ^wd[XLEN-1:HI_W];
  end

  if (EXT_W > 0) begin : g_ext
    assign acc_view = {{EXT_W{acc_q[ACC_W-1]}}, acc_q};
  end else begin : g_full
    assign acc_view = acc_q;
  end

endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
  import ctlreg_pkg::*;
#(
  parameter int ACC_W = 56,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cr_idx,
  output logic [31:0]       rd_data,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       sp_rd_data,
  input  logic              sp_wr_en,
  input  logic [31:0]       sp_wr_data,
  output logic [63:0]       acc_rd_data,
  input  logic              acc_lo_we,
  input  logic              acc_hi_we,
  input  logic [31:0]       acc_wr_data
);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // write decode
  logic we_status, we_cond, we_istack, we_ustack, we_status2;
  assign we_status  = wr_en && (cr_idx == IDX_W'(IX_STATUS));
  assign we_cond    = wr_en && (cr_idx == IDX_W'(IX_COND));
  assign we_istack  = wr_en && (cr_idx == IDX_W'(IX_ISTACK));
  assign we_ustack  = wr_en && (cr_idx == IDX_W'(IX_USTACK));
  assign we_status2 = wr_en && (cr_idx == IDX_W'(IX_STATUS2));

  logic [XLEN-1:0] status_view, cond_view, status2_view;
  logic            cur_sm, swap_req;

  cr_psw_unit u_psw (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .we_status    (we_status),
    .we_cond      (we_cond),
    .we_status2   (we_status2),
    .wd           (wr_data[15:0]),
    .status_view  (status_view),
    .cond_view    (cond_view),
    .status2_view (status2_view),
    .cur_sm       (cur_sm),
    .swap_req     (swap_req)
  );

  logic [XLEN-1:0] live_sp, isp_bank, usp_bank;

  cr_stack_bank u_stack (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .cur_sm    (cur_sm),
    .swap_req  (swap_req),
    .we_istack (we_istack),
    .we_ustack (we_ustack),
    .wd        (wr_data),
    .sp_we     (sp_wr_en),
    .sp_wd     (sp_wr_data),
    .live_sp   (live_sp),
    .isp_bank  (isp_bank),
    .usp_bank  (usp_bank)
  );

  logic [STORE_N-1:0][XLEN-1:0] store_views;

  cr_store_bank #(.IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .rst_ni (rst_ni),
    .wr_en  (wr_en),
    .idx    (cr_idx),
    .wd     (wr_data),
    .views  (store_views)
  );

  cr_mac_acc #(.ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .lo_we    (acc_lo_we),
    .hi_we    (acc_hi_we),
    .wd       (acc_wr_data),
    .acc_view (acc_rd_data)
  );

  // banked stack views follow the live mode
  logic [XLEN-1:0] istack_view, ustack_view;
  assign istack_view = cur_sm ? isp_bank : live_sp;
  assign ustack_view = cur_sm ? live_sp  : usp_bank;

  always_comb begin
    rd_data = '0;
    case (cr_idx)
      IDX_W'(IX_STATUS):  rd_data = status_view;
      IDX_W'(IX_COND):    rd_data = cond_view;
      IDX_W'(IX_ISTACK):  rd_data = istack_view;
      IDX_W'(IX_USTACK):  rd_data = ustack_view;
      IDX_W'(IX_SPARE0):  rd_data = store_views[0];
      IDX_W'(IX_SPARE1):  rd_data = store_views[1];
      IDX_W'(IX_RET0):    rd_data = store_views[2];
      IDX_W'(IX_RET1):    rd_data = store_views[3];
      IDX_W'(IX_STATUS2): rd_data = status2_view;
      default:            rd_data = '0;
    endcase
  end

  assign sp_rd_data = live_sp;

endmodule

// File: rtl/ctlreg_file_chk.sv
module ctlreg_file_chk #(
  parameter int ACC_W = 56,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_ni,
  input logic [IDX_W-1:0] cr_idx,
  input logic [31:0]      rd_data,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      sp_rd_data,
  input logic             sp_wr_en,
  input logic [31:0]      sp_wr_data,
  input logic [63:0]      acc_rd_data,
  input logic             acc_lo_we,
  input logic             acc_hi_we,
  input logic [31:0]      live_sp,
  input logic [31:0]      isp_bank,
  input logic [31:0]      usp_bank,
  input logic             cur_sm
);

  logic status_wr;
  assign status_wr = wr_en && (cr_idx == IDX_W'(0));

  assert_status_zero_bits_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (cr_idx == IDX_W'(0)) |-> ((rd_data & ~32'h0000_C1C1) == 32'h0));

  assert_swap_to_user_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (status_wr && wr_data[7] && !cur_sm) |=>
      (isp_bank == $past(live_sp) && live_sp == $past(usp_bank)));

  assert_swap_to_irq_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (status_wr && !wr_data[7] && cur_sm) |=>
      (usp_bank == $past(live_sp) && live_sp == $past(isp_bank)));

  assert_no_swap_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (status_wr && (wr_data[7] == cur_sm)) |=> ($stable(isp_bank) && $stable(usp_bank)));

  assert_even_return_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (cr_idx == IDX_W'(6) || cr_idx == IDX_W'(7)) |-> (rd_data[0] == 1'b0));

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (cr_idx >= IDX_W'(9)) |-> (rd_data == 32'h0));

  assert_acc_sign_ext_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_rd_data[63:ACC_W-1] == {(65-ACC_W){acc_rd_data[ACC_W-1]}});

  assert_acc_lo_keeps_hi_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_lo_we && !acc_hi_we) |=> (acc_rd_data[63:32] == $past(acc_rd_data[63:32])));

  assert_sp_port_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (sp_wr_en && !(wr_en && (cr_idx == IDX_W'(0) || cr_idx == IDX_W'(2) || cr_idx == IDX_W'(3))))
      |=> (sp_rd_data == $past(sp_wr_data)));

endmodule

bind ctlreg_file ctlreg_file_chk #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_ni),
  .cr_idx      (cr_idx),
  .rd_data     (rd_data),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .sp_rd_data  (sp_rd_data),
  .sp_wr_en    (sp_wr_en),
  .sp_wr_data  (sp_wr_data),
  .acc_rd_data (acc_rd_data),
  .acc_lo_we   (acc_lo_we),
  .acc_hi_we   (acc_hi_we),
  .live_sp     (live_sp),
  .isp_bank    (isp_bank),
  .usp_bank    (usp_bank),
  .cur_sm      (cur_sm)
);

// File: tb/test_ctlreg_file.sv
`timescale 1ns/1ps
module test_ctlreg_file;

  logic        clk;
  logic        rst_n;
  logic [3:0]  cr_idx;
  logic [31:0] rd_data;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] sp_rd_data;
  logic        sp_wr_en;
  logic [31:0] sp_wr_data;
  logic [63:0] acc_rd_data;
  logic        acc_lo_we;
  logic        acc_hi_we;
  logic [31:0] acc_wr_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  ctlreg_file i_ctlreg_file (
    .clk         (clk),
    .rst_n       (rst_n),
    .cr_idx      (cr_idx),
    .rd_data     (rd_data),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .sp_rd_data  (sp_rd_data),
    .sp_wr_en    (sp_wr_en),
    .sp_wr_data  (sp_wr_data),
    .acc_rd_data (acc_rd_data),
    .acc_lo_we   (acc_lo_we),
    .acc_hi_we   (acc_hi_we),
    .acc_wr_data (acc_wr_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // read is combinational: present index just after a falling edge
  task automatic rd(input logic [3:0] idx, output logic [31:0] val);
    cr_idx = idx;
    #1;
    val = rd_data;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    cr_idx = idx; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), v);
      chk("R11 reset read", {32'b0, v}, 64'h0);
    end
    chk("R11 reset sp", {32'b0, sp_rd_data}, 64'h0);
    chk("R11 reset acc", acc_rd_data, 64'h0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    @(negedge clk);
    cr_idx = 4'd4; wr_en = 1'b1; wr_data = 32'h0000_AAAA;
    #1;
    chk("R12 old value during write", {32'b0, rd_data}, 64'h0);
    @(negedge clk);
    wr_en = 1'b0;
    rd(4'd4, v);
    chk("R12 new value after edge", {32'b0, v}, 64'h0000_AAAA);
  endtask

  task automatic t_status;
    logic [31:0] v;
    wr(4'd0, 32'hFFFF_FF41);
    rd(4'd0, v);
    chk("R1 R2 status compose", {32'b0, v}, 64'h0000_C141);
    rd(4'd1, v);
    chk("R3 cond read", {32'b0, v}, 64'h1);
    wr(4'd1, 32'hFFFF_FFFE);
    rd(4'd0, v);
    chk("R3 cond write via status", {32'b0, v}, 64'h0000_C140);
    rd(4'd1, v);
    chk("R3 cond read zero", {32'b0, v}, 64'h0);
    chk("R4 no swap sm stays 0", {32'b0, sp_rd_data}, 64'h0);
  endtask

  task automatic t_stack;
    logic [31:0] v;
    @(negedge clk);
    sp_wr_en = 1'b1; sp_wr_data = 32'h0000_1000;
    @(negedge clk);
    sp_wr_en = 1'b0;
    chk("R10 sp port write", {32'b0, sp_rd_data}, 64'h1000);
    rd(4'd2, v);
    chk("R5 istack is live at mode 0", {32'b0, v}, 64'h1000);
    wr(4'd3, 32'h0000_2000);
    chk("R5 ustack write goes to bank", {32'b0, sp_rd_data}, 64'h1000);
    wr(4'd0, 32'h0000_0080);
    chk("R4 swap to user live", {32'b0, sp_rd_data}, 64'h2000);
    rd(4'd2, v);
    chk("R4 istack bank saved", {32'b0, v}, 64'h1000);
    rd(4'd3, v);
    chk("R5 ustack is live at mode 1", {32'b0, v}, 64'h2000);
    wr(4'd0, 32'h0000_0081);
    chk("R4 no swap when mode kept", {32'b0, sp_rd_data}, 64'h2000);
    rd(4'd2, v);
    chk("R4 istack bank kept", {32'b0, v}, 64'h1000);
    wr(4'd2, 32'h0000_3000);
    chk("R5 istack write goes to bank", {32'b0, sp_rd_data}, 64'h2000);
    wr(4'd0, 32'h0000_0000);
    chk("R4 swap to irq live", {32'b0, sp_rd_data}, 64'h3000);
    rd(4'd3, v);
    chk("R4 ustack bank saved", {32'b0, v}, 64'h2000);
  endtask

  task automatic t_priority;
    @(negedge clk);
    cr_idx = 4'd2; wr_en = 1'b1; wr_data = 32'h0000_4000;
    sp_wr_en = 1'b1; sp_wr_data = 32'h0000_5000;
    @(negedge clk);
    wr_en = 1'b0; sp_wr_en = 1'b0;
    chk("R10 control write wins", {32'b0, sp_rd_data}, 64'h4000);
    @(negedge clk);
    cr_idx = 4'd4; wr_en = 1'b1; wr_data = 32'h0;
    sp_wr_en = 1'b1; sp_wr_data = 32'h0000_6000;
    @(negedge clk);
    wr_en = 1'b0; sp_wr_en = 1'b0;
    chk("R10 sp port with unrelated write", {32'b0, sp_rd_data}, 64'h6000);
  endtask

  task automatic t_backup;
    logic [31:0] v;
    wr(4'd6, 32'hFFFF_FFFF);
    rd(4'd6, v);
    chk("R6 return0 even", {32'b0, v}, 64'hFFFF_FFFE);
    wr(4'd7, 32'h1234_5679);
    rd(4'd7, v);
    chk("R6 return1 even", {32'b0, v}, 64'h1234_5678);
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, v);
    chk("R7 status2 mask", {32'b0, v}, 64'hC1);
    wr(4'd8, 32'h0000_0040);
    rd(4'd8, v);
    chk("R7 status2 bit6", {32'b0, v}, 64'h40);
  endtask

  task automatic t_spare;
    logic [31:0] v;
    wr(4'd4, 32'hDEAD_BEEF);
    wr(4'd5, 32'h0123_4567);
    rd(4'd4, v);
    chk("R8 spare0", {32'b0, v}, 64'hDEAD_BEEF);
    rd(4'd5, v);
    chk("R8 spare1", {32'b0, v}, 64'h0123_4567);
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    rd(4'd9, v);
    chk("R8 index 9 reads zero", {32'b0, v}, 64'h0);
    rd(4'd15, v);
    chk("R8 index 15 reads zero", {32'b0, v}, 64'h0);
    rd(4'd4, v);
    chk("R8 unmapped write left spare0", {32'b0, v}, 64'hDEAD_BEEF);
    rd(4'd0, v);
    chk("R8 unmapped write left status", {32'b0, v}, 64'h0);
    rd(4'd8, v);
    chk("R8 unmapped write left status2", {32'b0, v}, 64'h40);
    chk("R8 unmapped write left sp", {32'b0, sp_rd_data}, 64'h6000);
  endtask

  task automatic t_acc;
    @(negedge clk);
    acc_lo_we = 1'b1; acc_wr_data = 32'h89AB_CDEF;
    @(negedge clk);
    acc_lo_we = 1'b0; acc_hi_we = 1'b1; acc_wr_data = 32'h0080_0001;
    @(negedge clk);
    acc_hi_we = 1'b0;
    chk("R9 negative sign extend", acc_rd_data, 64'hFF80_0001_89AB_CDEF);
    @(negedge clk);
    acc_lo_we = 1'b1; acc_wr_data = 32'h1111_1111;
    @(negedge clk);
    acc_lo_we = 1'b0;
    chk("R9 low write keeps high", acc_rd_data, 64'hFF80_0001_1111_1111);
    @(negedge clk);
    acc_hi_we = 1'b1; acc_wr_data = 32'h7F12_3456;
    @(negedge clk);
    acc_hi_we = 1'b0;
    chk("R9 high write keeps low", acc_rd_data, 64'h0012_3456_1111_1111);
  endtask

  initial begin
    rst_n = 1'b0; cr_idx = '0; wr_en = 1'b0; wr_data = '0;
    sp_wr_en = 1'b0; sp_wr_data = '0;
    acc_lo_we = 1'b0; acc_hi_we = 1'b0; acc_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_same_cycle();
    t_status();
    t_stack();
    t_priority();
    t_backup();
    t_spare();
    t_acc();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule